// File: doc/BRIEF.md
# Shift, Rotate and Nibble-Rotate Unit

This block is the combinational shifter of an 8-bit processor datapath. It takes an operation code, a primary operand, a second byte and the current flag byte. It returns a primary result, a secondary result and the updated flag byte in the same cycle. Operand fetch, memory access and write-back are handled by the surrounding datapath.

Each operation has its own rule for three things: what fills the vacated bit, where the carry comes from, and which flags it updates. The general shifts and rotates recompute every status flag. The four accumulator fast rotates change only the carry and the two arithmetic-mode flags. The two nibble rotates treat the low digit of the accumulator and the memory byte together as one 12-bit value and move 4-bit digits between the two bytes.

The flag byte has a fixed layout because neighbouring logic decodes it:

| Bit | Flag |
|-----|------|
| 7 | sign |
| 6 | zero |
| 5 | unused |
| 4 | half-carry |
| 3 | unused |
| 2 | parity/overflow |
| 1 | subtract |
| 0 | carry |

Bits 5 and 3 always pass through unchanged. Parity is 1 when the result holds an even number of ones.

There are no registers in the block. The style's state dispatch becomes a `unique case` on the operation code inside each stage.

Top module: `shift_rotate_unit`

## Requirements
- R1: Code 0 (arithmetic left) returns the operand shifted one place toward bit 7 with bit 0 cleared. The carry receives the old bit 7.
- R2: Code 1 (arithmetic right) keeps bit 7 and shifts the other bits one place toward bit 0. The carry receives the old bit 0.
- R3: Code 2 (logical right) shifts toward bit 0 with bit 7 cleared. The carry receives the old bit 0.
- R4: Code 3 (left with one-fill) shifts toward bit 7 and sets bit 0. The old bit 7 is lost and the carry is cleared.
- R5: Code 4 (left through carry) puts the old carry into bit 0 and the old bit 7 into the carry. Code 5 (right through carry) puts the old carry into bit 7 and the old bit 0 into the carry.
- R6: Code 6 (circular left) copies the old bit 7 into both bit 0 and the carry. Code 7 (circular right) copies the old bit 0 into both bit 7 and the carry.
- R7: Codes 0 to 7 set the flags as follows:
  - half-carry and subtract are cleared;
  - sign is result bit 7;
  - zero is set when the result is 0;
  - parity/overflow is the even parity of the result.
- R8: Codes 8, 9, 10 and 11 give the same result and carry as codes 4, 5, 6 and 7 respectively. They clear half-carry and subtract and leave sign, zero and parity/overflow unchanged.
- R9: Code 12 (nibble left), with operand aaaaxxxx and second byte yyyyzzzz, returns result aaaayyyy and secondary result zzzzxxxx.
- R10: Code 13 (nibble right), with the same inputs, returns result aaaazzzz and secondary result xxxxyyyy.
- R11: Codes 12 and 13 keep the carry and clear half-carry and subtract. They take sign, zero and even parity from the new result.
- R12: For every code other than 12 and 13, the secondary result equals the second byte. Codes 14 and 15 return the operand and the flag byte unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_code | input | 4 | Operation select, codes 0 to 15 |
| opnd_in | input | 8 | Primary operand (accumulator for nibble rotates) |
| aux_in | input | 8 | Second byte used by the nibble rotates |
| flags_in | input | 8 | Incoming flag byte |
| res_out | output | 8 | Primary result |
| aux_out | output | 8 | Secondary result |
| flags_out | output | 8 | Updated flag byte |

## Verification
The bench builds the unit with its default 8-bit data width. At that width every operand pattern is in reach, and the bench sweeps all sixteen codes against both carry polarities. The sweep runs operands with bit 7 and bit 0 in each combination, values that shift to zero, and values of both parities. It also varies the second byte, so digit movement can be told apart from pass-through.

// File: rtl/shru_pkg.sv
package shru_pkg;

    localparam int FLAG_W = 8;
    localparam int FB_S   = 7;
    localparam int FB_Z   = 6;
    localparam int FB_H   = 4;
    localparam int FB_PV  = 2;
    localparam int FB_N   = 1;
    localparam int FB_C   = 0;

    typedef enum logic [3:0] {
        OP_ASL        = 4'd0,
        OP_ASR        = 4'd1,
        OP_LSR        = 4'd2,
        OP_SHL_ONE    = 4'd3,
        OP_ROT_CL     = 4'd4,
        OP_ROT_CR     = 4'd5,
        OP_CIRC_L     = 4'd6,
        OP_CIRC_R     = 4'd7,
        OP_ACC_ROT_CL = 4'd8,
        OP_ACC_ROT_CR = 4'd9,
        OP_ACC_CIRC_L = 4'd10,
        OP_ACC_CIRC_R = 4'd11,
        OP_NIB_L      = 4'd12,
        OP_NIB_R      = 4'd13,
        OP_RSV_E      = 4'd14,
        OP_RSV_F      = 4'd15
    } shru_op_e;

    typedef enum logic [1:0] {
        CLS_FULL,
        CLS_FAST,
        CLS_NIB,
        CLS_PASS
    } shru_cls_e;

endpackage

// File: rtl/shru_bitops.sv
module shru_bitops
    import shru_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  shru_op_e          op,
    input  logic [DATA_W-1:0] din,
    input  logic              cin,
    output logic [DATA_W-1:0] dout,
    output logic              cout
);
    localparam int MSB = DATA_W - 1;

    always_comb begin
        dout = din;
        cout = cin;
        unique case (op)
            OP_ASL: begin
                dout = {din[MSB-1:0], 1'b0};
                cout = din[MSB];
            end
            OP_ASR: begin
                dout = {din[MSB], din[MSB:1]};
                cout = din[0];
            end
            OP_LSR: begin
                dout = {1'b0, din[MSB:1]};
                cout = din[0];
            end
            OP_SHL_ONE: begin
                dout = {din[MSB-1:0], 1'b1};
                cout = 1'b0;
            end
            OP_ROT_CL, OP_ACC_ROT_CL: begin
                dout = {din[MSB-1:0], cin};
                cout = din[MSB];
            end
            OP_ROT_CR, OP_ACC_ROT_CR: begin
                dout = {cin, din[MSB:1]};
                cout = din[0];
            end
            OP_CIRC_L, OP_ACC_CIRC_L: begin
                dout = {din[MSB-1:0], din[MSB]};
                cout = din[MSB];
            end
            OP_CIRC_R, OP_ACC_CIRC_R: begin
                dout = {din[0], din[MSB:1]};
                cout = din[0];
            end
            default: begin
                dout = din;
                cout = cin;
            end
        endcase
    end

    always_comb begin
        if (op == OP_ASL)
            a_r1_asl_fill: assert (dout[0] == 1'b0 && cout == din[MSB])
                else $error("a_r1_asl_fill");
        if (op == OP_SHL_ONE)
            a_r4_one_fill: assert (dout[0] == 1'b1 && cout == 1'b0)
                else $error("a_r4_one_fill");
        if (op == OP_ASR)
            a_r2_sign_kept: assert (dout[MSB] == din[MSB])
                else $error("a_r2_sign_kept");
    end

endmodule

// File: rtl/shru_nibble.sv
module shru_nibble
    import shru_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  shru_op_e          op,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] mem,
    output logic [DATA_W-1:0] acc_n,
    output logic [DATA_W-1:0] mem_n
);
    localparam int HALF = DATA_W / 2;

    logic [HALF-1:0] a_hi, a_lo, m_hi, m_lo;
    assign a_hi = acc[DATA_W-1:HALF];
    assign a_lo = acc[HALF-1:0];
    assign m_hi = mem[DATA_W-1:HALF];
    assign m_lo = mem[HALF-1:0];

    always_comb begin
        acc_n = acc;
        mem_n = mem;
        unique case (op)
            OP_NIB_L: begin
                acc_n = {a_hi, m_hi};
                mem_n = {m_lo, a_lo};
            end
            OP_NIB_R: begin
                acc_n = {a_hi, m_lo};
                mem_n = {a_lo, m_hi};
            end
            default: begin
                acc_n = acc;
                mem_n = mem;
            end
        endcase
    end

    always_comb begin
        if (op == OP_NIB_L || op == OP_NIB_R)
            a_r9_upper_digit_kept: assert (acc_n[DATA_W-1:HALF] == acc[DATA_W-1:HALF])
                else $error("a_r9_upper_digit_kept");
    end

endmodule

// File: rtl/shru_flags.sv
module shru_flags
    import shru_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  shru_cls_e         cls,
    input  logic [DATA_W-1:0] result,
    input  logic              cnew,
    input  logic [FLAG_W-1:0] fin,
    output logic [FLAG_W-1:0] fout
);
    logic sgn, zer, par;
    assign sgn = result[DATA_W-1];
    assign zer = (result == '0);
    assign par = ~(^result);

    always_comb begin
        fout = fin;
        unique case (cls)
            CLS_FULL: begin
                fout[FB_S]  = sgn;
                fout[FB_Z]  = zer;
                fout[FB_PV] = par;
                fout[FB_H]  = 1'b0;
                fout[FB_N]  = 1'b0;
                fout[FB_C]  = cnew;
            end
            CLS_FAST: begin
                fout[FB_H]  = 1'b0;
                fout[FB_N]  = 1'b0;
                fout[FB_C]  = cnew;
            end
            CLS_NIB: begin
                fout[FB_S]  = sgn;
                fout[FB_Z]  = zer;
                fout[FB_PV] = par;
                fout[FB_H]  = 1'b0;
                fout[FB_N]  = 1'b0;
            end
            CLS_PASS: fout = fin;
        endcase
    end

    always_comb begin
        if (cls == CLS_FAST)
            a_r8_fast_keeps_szp: assert (fout[FB_S] == fin[FB_S] && fout[FB_Z] == fin[FB_Z]
                                         && fout[FB_PV] == fin[FB_PV])
                else $error("a_r8_fast_keeps_szp");
        if (cls == CLS_NIB)
            a_r11_carry_kept: assert (fout[FB_C] == fin[FB_C])
                else $error("a_r11_carry_kept");
    end

endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
    import shru_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [3:0]        op_code,
    input  logic [DATA_W-1:0] opnd_in,
    input  logic [DATA_W-1:0] aux_in,
    input  logic [FLAG_W-1:0] flags_in,
    output logic [DATA_W-1:0] res_out,
    output logic [DATA_W-1:0] aux_out,
    output logic [FLAG_W-1:0] flags_out
);
    shru_op_e  op;
    shru_cls_e cls;
    logic [DATA_W-1:0] bit_res, nib_acc, nib_mem;
    logic              bit_c;

    assign op = shru_op_e'(op_code);

    always_comb begin
        unique case (op)
            OP_ASL, OP_ASR, OP_LSR, OP_SHL_ONE,
            OP_ROT_CL, OP_ROT_CR, OP_CIRC_L, OP_CIRC_R:               cls = CLS_FULL;
            OP_ACC_ROT_CL, OP_ACC_ROT_CR, OP_ACC_CIRC_L, OP_ACC_CIRC_R: cls = CLS_FAST;
            OP_NIB_L, OP_NIB_R:                                       cls = CLS_NIB;
            default:                                                  cls = CLS_PASS;
        endcase
    end

    shru_bitops #(.DATA_W(DATA_W)) u_bitops (
        .op   (op),
        .din  (opnd_in),
        .cin  (flags_in[FB_C]),
        .dout (bit_res),
        .cout (bit_c)
    );

    shru_nibble #(.DATA_W(DATA_W)) u_nibble (
        .op    (op),
        .acc   (opnd_in),
        .mem   (aux_in),
        .acc_n (nib_acc),
        .mem_n (nib_mem)
    );

    always_comb begin
        if (cls == CLS_NIB) begin
            res_out = nib_acc;
            aux_out = nib_mem;
        end else begin
            res_out = bit_res;
            aux_out = aux_in;
        end
    end

    shru_flags #(.DATA_W(DATA_W)) u_flags (
        .cls    (cls),
        .result (res_out),
        .cnew   (bit_c),
        .fin    (flags_in),
        .fout   (flags_out)
    );

    always_comb begin
        if (cls != CLS_NIB)
            a_r12_aux_passthrough: assert (aux_out == aux_in)
                else $error("a_r12_aux_passthrough");
        if (cls == CLS_FULL)
            a_r7_zero_tracks_result: assert (flags_out[FB_Z] == (res_out == '0)
                                             && flags_out[FB_H] == 1'b0)
                else $error("a_r7_zero_tracks_result");
    end

endmodule

// File: tb/shift_rotate_unit_bench.sv
module shift_rotate_unit_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] op_code;
    logic [7:0] opnd_in, aux_in, flags_in;
    logic [7:0] res_out, aux_out, flags_out;

    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] r;
        logic [7:0] s;
        logic [7:0] f;
        string      tag;
    } exp_t;

    exp_t sb_q[$];

    always #5 clk = ~clk;

    shift_rotate_unit u_shift_rotate_unit (
        .op_code   (op_code),
        .opnd_in   (opnd_in),
        .aux_in    (aux_in),
        .flags_in  (flags_in),
        .res_out   (res_out),
        .aux_out   (aux_out),
        .flags_out (flags_out)
    );

    function automatic exp_t model(input int op, input logic [7:0] a,
                                   input logic [7:0] m, input logic [7:0] f);
        exp_t e;
        logic c;
        logic recompute;
        c = f[0];
        e.r = a;
        e.s = m;
        e.f = f;
        recompute = 1'b1;
        case (op)
            0: begin e.r = a << 1; e.f[0] = a[7]; e.tag = "R1"; end
            1: begin e.r = (a >> 1) | (a & 8'h80); e.f[0] = a[0]; e.tag = "R2"; end
            2: begin e.r = a >> 1; e.f[0] = a[0]; e.tag = "R3"; end
            3: begin e.r = (a << 1) | 8'h01; e.f[0] = 1'b0; e.tag = "R4"; end
            4, 8: begin e.r = (a << 1) | {7'd0, c}; e.f[0] = a[7]; e.tag = (op == 4) ? "R5" : "R8"; end
            5, 9: begin e.r = (a >> 1) | {c, 7'd0}; e.f[0] = a[0]; e.tag = (op == 5) ? "R5" : "R8"; end
            6, 10: begin e.r = (a << 1) | (a >> 7); e.f[0] = a[7]; e.tag = (op == 6) ? "R6" : "R8"; end
            7, 11: begin e.r = (a >> 1) | (a << 7); e.f[0] = a[0]; e.tag = (op == 7) ? "R6" : "R8"; end
            12: begin e.r = (a & 8'hF0) | (m >> 4); e.s = (m << 4) | (a & 8'h0F); e.tag = "R9"; end
            13: begin e.r = (a & 8'hF0) | (m & 8'h0F); e.s = ((a & 8'h0F) << 4) | (m >> 4); e.tag = "R10"; end
            default: begin recompute = 1'b0; e.tag = "R12"; end
        endcase
        if (recompute) begin
            e.f[4] = 1'b0;
            e.f[1] = 1'b0;
            if (op < 8 || op > 11) begin
                e.f[7] = e.r[7];
                e.f[6] = (e.r == 8'h00);
                e.f[2] = ($countones(e.r) % 2) == 0;
            end
        end
        return e;
    endfunction

    task automatic apply(input int op, input logic [7:0] a, input logic [7:0] m,
                         input logic [7:0] f);
        exp_t e;
        @(posedge clk);
        #1;
        op_code  = op[3:0];
        opnd_in  = a;
        aux_in   = m;
        flags_in = f;
        e = model(op, a, m, f);
        sb_q.push_back(e);
    endtask

    always @(negedge clk) begin
        if (!rst && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_vec++;
            if (res_out !== e.r || aux_out !== e.s || flags_out !== e.f) begin
                n_bad++;
                $display("FAIL %s op=%0d a=%02h m=%02h f=%02h: got r=%02h s=%02h f=%02h exp r=%02h s=%02h f=%02h",
                         e.tag, op_code, opnd_in, aux_in, flags_in,
                         res_out, aux_out, flags_out, e.r, e.s, e.f);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (!done && cycles > 150000) begin
            n_bad++;
            $display("FAIL watchdog: got cycles=%0d exp done", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] pats [12];
        pats = '{8'h00, 8'h01, 8'h80, 8'h81, 8'hFF, 8'h7E, 8'h55, 8'hAA,
                 8'h3C, 8'h12, 8'hC3, 8'h40};
        op_code = 4'd0; opnd_in = 8'h00; aux_in = 8'h00; flags_in = 8'h00;
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // reset-like idle: all-zero inputs, R1 and R7 zero-flag case
        apply(0, 8'h00, 8'h00, 8'h00);
        // R1 R2 R3 R4 directed corners
        apply(0, 8'h80, 8'h00, 8'h00);
        apply(1, 8'h81, 8'h00, 8'h00);
        apply(2, 8'h01, 8'h00, 8'hFF);
        apply(3, 8'hFF, 8'h00, 8'h01);
        // R5 R6 carry in both polarities
        apply(4, 8'h00, 8'h00, 8'h01);
        apply(5, 8'h00, 8'h00, 8'h01);
        apply(6, 8'h80, 8'h00, 8'h00);
        apply(7, 8'h01, 8'h00, 8'h00);
        // R8 fast forms keep S Z PV; R11 nibble keeps carry
        apply(8, 8'h00, 8'h00, 8'hFF);
        apply(11, 8'hFF, 8'h00, 8'h00);
        apply(12, 8'hA5, 8'h3C, 8'h01);
        apply(13, 8'hA5, 8'h3C, 8'h01);
        // R9 R10 R12 sweep over all codes and patterns
        for (int op = 0; op < 16; op++) begin
            for (int i = 0; i < 12; i++) begin
                for (int cf = 0; cf < 2; cf++) begin
                    apply(op, pats[i], pats[(i + 5) % 12] ^ 8'h69,
                          (cf == 1) ? 8'hD7 : 8'h28);
                end
            end
        end
        @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule